// File: doc/BRIEF.md
# Timer Compare Unit with Output Latch

This block watches a free-running 16-bit timer and compares it every clock cycle against a compare register that software loads through a simple write port. When the two values first become equal, the unit takes the action chosen by a 4-bit mode field. It can drive an output latch high or low, or raise only the interrupt flag. In a fourth mode it sends a single-cycle pulse that the timer uses to restart from zero.

Every match sets a sticky interrupt flag, which software clears with a strobe. The output latch reaches the pin only when the pin's direction input selects output. Writing the all-zero mode forces the latch back to its default low level. The timer itself, the port direction register and the bus decoder are outside this block.

Top module: `tcu_compare_top`

## Requirements
- R1: A write on the compare write port loads the compare register at that clock edge. Comparisons in the same cycle still use the old value, and the new value is used from the next cycle on.
- R2: A match is recognised only in the cycle where equality first becomes true, with a mode in 1000..1011. While the timer stays equal, no further action fires.
- R3: With mode 1000, a match sets the output latch to 1 at the clock edge that ends the match cycle.
- R4: With mode 1001, a match clears the output latch to 0 at the clock edge that ends the match cycle.
- R5: With mode 1010, a match sets the interrupt flag and leaves the output latch unchanged.
- R6: With mode 1011, a match makes the timer-reset output high for exactly one cycle, starting after the edge that ends the match cycle. The output latch is unchanged.
- R7: Every match sets the interrupt flag at the same edge as the pin action. The flag stays set until the clear strobe.
- R8: When a match and the clear strobe fall in the same cycle, the flag ends up set.
- R9: Mode 0000 forces the output latch to 0 at the next clock edge.
- R10: Any nonzero mode outside 1000..1011 disables matching. The latch holds, and the flag and the reset pulse stay unchanged.
- R11: The pin output equals the latch when the direction input is 1, and is 0 otherwise. The pin enable output follows the direction input.
- R12: Reloading the compare register while a match is in progress does not fire the action again until equality is newly reached.
- R13: After synchronous reset the latch, the flag and the reset pulse are 0, and the compare register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_val | input | 16 | Current timer count |
| cmp_wr_en | input | 1 | Load strobe for the compare register |
| cmp_wr_data | input | 16 | Value loaded into the compare register |
| mode | input | 4 | Compare action select |
| flag_clr | input | 1 | Clears the interrupt flag |
| dir_out | input | 1 | 1 selects the pin as an output |
| pin_o | output | 1 | Pin level driven by the output latch |
| pin_oe | output | 1 | Pin output enable |
| irq_flag | output | 1 | Sticky match interrupt flag |
| tmr_rst_pulse | output | 1 | One-cycle timer restart request |

## Verification
The assertions assume that the mode field is stable for a cycle and that the timer input is a plain value with no glitch inside a cycle. They treat a change of mode between an active encoding and another encoding as a legitimate new start of equality. The stimulus changes the mode only at negative clock edges and steps the timer in large jumps. As a result, each equality window opens and closes under a known mode, and the cycles in which a match fires are fixed in advance.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    localparam int TMR_W  = 16;
    localparam int MODE_W = 4;

    typedef enum logic [2:0] {
        ACT_OFF,    // mode zero: force latch low
        ACT_IDLE,   // disabled, latch holds
        ACT_HIGH,
        ACT_LOW,
        ACT_FLAG,
        ACT_TRIG
    } cmp_act_e;

    typedef struct packed {
        logic     hit;
        cmp_act_e act;
    } match_ev_t;

    function automatic cmp_act_e decode_mode(input logic [MODE_W-1:0] m);
        cmp_act_e a;
        case (m)
            4'b0000: a = ACT_OFF;
            4'b1000: a = ACT_HIGH;
            4'b1001: a = ACT_LOW;
            4'b1010: a = ACT_FLAG;
            4'b1011: a = ACT_TRIG;
            default: a = ACT_IDLE;
        endcase
        return a;
    endfunction

    function automatic logic act_is_live(input cmp_act_e a);
        return (a == ACT_HIGH) || (a == ACT_LOW) || (a == ACT_FLAG) || (a == ACT_TRIG);
    endfunction

endpackage

// File: rtl/tcu_match_det.sv
module tcu_match_det #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] tmr,
    input  logic         live,
    output logic         hit,
    output logic [W-1:0] cmp_q
);
    logic eq_now;
    logic eq_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (wr_en) begin
            cmp_q <= wr_data;
        end
    end

    assign eq_now = live && (tmr == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            eq_prev <= 1'b0;
        end else begin
            eq_prev <= eq_now;
        end
    end

    assign hit = eq_now && !eq_prev;

endmodule

// File: rtl/tcu_out_latch.sv
module tcu_out_latch
    import tcu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  match_ev_t ev,
    output logic      latch_q,
    output logic      trig_q
);
    logic latch_d;

    always_comb begin
        latch_d = latch_q;
        if (ev.act == ACT_OFF) begin
            latch_d = 1'b0;
        end else if (ev.hit) begin
            case (ev.act)
                ACT_HIGH: latch_d = 1'b1;
                ACT_LOW:  latch_d = 1'b0;
                default:  latch_d = latch_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            trig_q  <= 1'b0;
        end else begin
            latch_q <= latch_d;
            trig_q  <= ev.hit && (ev.act == ACT_TRIG);
        end
    end

endmodule

// File: rtl/tcu_irq_flag.sv
module tcu_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/tcu_compare_top.sv
module tcu_compare_top
    import tcu_pkg::*;
#(
    parameter int CNT_W = TMR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  tmr_val,
    input  logic              cmp_wr_en,
    input  logic [CNT_W-1:0]  cmp_wr_data,
    input  logic [MODE_W-1:0] mode,
    input  logic              flag_clr,
    input  logic              dir_out,
    output logic              pin_o,
    output logic              pin_oe,
    output logic              irq_flag,
    output logic              tmr_rst_pulse
);
    cmp_act_e         act;
    logic             match_hit;
    logic             out_latch;
    logic [CNT_W-1:0] cmp_reg;
    match_ev_t        ev;

    assign act = decode_mode(mode);

    tcu_match_det #(.W(CNT_W)) u_det (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmp_wr_en),
        .wr_data (cmp_wr_data),
        .tmr     (tmr_val),
        .live    (act_is_live(act)),
        .hit     (match_hit),
        .cmp_q   (cmp_reg)
    );

    assign ev.hit = match_hit;
    assign ev.act = act;

    tcu_out_latch u_lat (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .latch_q (out_latch),
        .trig_q  (tmr_rst_pulse)
    );

    tcu_irq_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .hit    (match_hit),
        .clr    (flag_clr),
        .flag_q (irq_flag)
    );

    assign pin_oe = dir_out;
    assign pin_o  = dir_out & out_latch;

endmodule

// File: rtl/tcu_compare_chk.sv
module tcu_compare_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] mode,
    input logic       flag_clr,
    input logic       dir_out,
    input logic       hit,
    input logic       latch,
    input logic       irq,
    input logic       trig,
    input logic       pin_o
);
    // R3
    set_high_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && mode == 4'b1000) |=> latch);

    // R4
    clear_low_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && mode == 4'b1001) |=> !latch);

    // R5
    flag_only_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && mode == 4'b1010) |=> $stable(latch));

    // R6
    trig_single_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);

    // R6
    trig_cause_chk: assert property (@(posedge clk) disable iff (rst)
        trig |-> ($past(hit) && $past(mode) == 4'b1011));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> irq);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !flag_clr) |=> irq);

    // R9
    off_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'b0000) |=> !latch);

    // R10
    idle_nohit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 4'b0000 && mode[3:2] != 2'b10) |-> !hit);

    // R11
    pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !dir_out |-> !pin_o);
endmodule

bind tcu_compare_top tcu_compare_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .flag_clr (flag_clr),
    .dir_out  (dir_out),
    .hit      (match_hit),
    .latch    (out_latch),
    .irq      (irq_flag),
    .trig     (tmr_rst_pulse),
    .pin_o    (pin_o)
);

// File: tb/tb_tcu_compare_top.sv
module tb_tcu_compare_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] tmr_val;
    logic        cmp_wr_en;
    logic [15:0] cmp_wr_data;
    logic [3:0]  mode;
    logic        flag_clr;
    logic        dir_out;
    logic        pin_o, pin_oe, irq_flag, tmr_rst_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tcu_compare_top dut (
        .clk(clk), .rst(rst), .tmr_val(tmr_val), .cmp_wr_en(cmp_wr_en),
        .cmp_wr_data(cmp_wr_data), .mode(mode), .flag_clr(flag_clr),
        .dir_out(dir_out), .pin_o(pin_o), .pin_oe(pin_oe),
        .irq_flag(irq_flag), .tmr_rst_pulse(tmr_rst_pulse)
    );

    // {wr, wdata, tmr, mode, clr, exp_latch, exp_flag, exp_trig, req}
    localparam int NV = 20;
    localparam logic [48:0] VEC [NV] = '{
        {1'b1, 16'd100, 16'd0,   4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 load 100
        {1'b0, 16'd0,   16'd50,  4'b1000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 no equality
        {1'b0, 16'd0,   16'd100, 4'b1000, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3},  // R3 set high
        {1'b0, 16'd0,   16'd100, 4'b1000, 1'b1, 1'b1, 1'b0, 1'b0, 8'd2},  // R2 held equal, no refire
        {1'b0, 16'd0,   16'd101, 4'b1001, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2},
        {1'b0, 16'd0,   16'd100, 4'b1001, 1'b0, 1'b0, 1'b1, 1'b0, 8'd4},  // R4 clear low
        {1'b1, 16'd200, 16'd100, 4'b1001, 1'b1, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 clear flag
        {1'b0, 16'd0,   16'd100, 4'b1001, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 new value in use
        {1'b0, 16'd0,   16'd200, 4'b1010, 1'b1, 1'b0, 1'b1, 1'b0, 8'd8},  // R8 / R5
        {1'b0, 16'd0,   16'd300, 4'b1011, 1'b0, 1'b0, 1'b1, 1'b0, 8'd7},  // R7 sticky
        {1'b0, 16'd0,   16'd200, 4'b1011, 1'b1, 1'b0, 1'b1, 1'b1, 8'd6},  // R6 trigger
        {1'b0, 16'd0,   16'd200, 4'b1011, 1'b0, 1'b0, 1'b1, 1'b0, 8'd6},  // R6 one cycle only
        {1'b0, 16'd0,   16'd0,   4'b1000, 1'b1, 1'b0, 1'b0, 1'b0, 8'd7},
        {1'b0, 16'd0,   16'd200, 4'b1000, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3},
        {1'b0, 16'd0,   16'd0,   4'b0101, 1'b1, 1'b1, 1'b0, 1'b0, 8'd10}, // R10 holds
        {1'b0, 16'd0,   16'd200, 4'b0101, 1'b0, 1'b1, 1'b0, 1'b0, 8'd10}, // R10 no match
        {1'b0, 16'd0,   16'd200, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9},  // R9 force low
        {1'b0, 16'd0,   16'd200, 4'b1000, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3},
        {1'b1, 16'd200, 16'd200, 4'b1000, 1'b1, 1'b1, 1'b0, 1'b0, 8'd12}, // R12 reload same
        {1'b0, 16'd0,   16'd200, 4'b1000, 1'b0, 1'b1, 1'b0, 1'b0, 8'd12}  // R12 no retrigger
    };

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tmr_val = '0; cmp_wr_en = 1'b0; cmp_wr_data = '0;
        mode = 4'b0000; flag_clr = 1'b0; dir_out = 1'b1;
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13", pin_o, 1'b0, "latch");
        check("R13", irq_flag, 1'b0, "flag");
        check("R13", tmr_rst_pulse, 1'b0, "pulse");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            cmp_wr_en   = VEC[i][48];
            cmp_wr_data = VEC[i][47:32];
            tmr_val     = VEC[i][31:16];
            mode        = VEC[i][15:12];
            flag_clr    = VEC[i][11];
            @(negedge clk);
            tag = $sformatf("R%0d v%0d", VEC[i][7:0], i);
            check(tag, pin_o, VEC[i][10], "latch");
            check(tag, irq_flag, VEC[i][9], "flag");
            check(tag, tmr_rst_pulse, VEC[i][8], "pulse");
        end
        cmp_wr_en = 1'b0; flag_clr = 1'b0;

        // R11 direction gating, latch currently 1
        dir_out = 1'b0;
        #1;
        check("R11", pin_o, 1'b0, "pin when input");
        check("R11", pin_oe, 1'b0, "oe when input");
        dir_out = 1'b1;
        #1;
        check("R11", pin_o, 1'b1, "pin when output");
        check("R11", pin_oe, 1'b1, "oe when output");

        // R13 reset mid-run clears latch and flag, compare register back to 0
        rst = 1'b1;
        @(negedge clk);
        check("R13", pin_o, 1'b0, "latch after reset");
        check("R13", irq_flag, 1'b0, "flag after reset");
        rst = 1'b0;
        mode = 4'b1000; tmr_val = 16'd0;
        @(negedge clk);
        check("R13", pin_o, 1'b1, "compare reg zero matches timer zero");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule